// File: doc/BRIEF.md
# Integer Execute Stage with Instruction Decode

This block is the combinational execute stage of a 32-bit integer pipeline that reads registers and writes them back in separate stages. Each cycle it takes one instruction word together with the two source register values that an earlier stage has already read. It decodes the word and computes the result. It also reports where that result goes and whether it may be written. The register file, multiply/divide, branches, jumps and memory access sit outside the block.

Two instruction layouts are recognised. The register form is selected by a zero major opcode and is then refined by the six-bit function field in bits [5:0]. Its destination index is bits [15:11] and its constant shift amount is bits [10:6]. The immediate form carries a 16-bit constant in bits [15:0] and writes to the index held in bits [20:16]. The first operand value always comes from `srcA`, which holds the value of the register named in bits [25:21]. The second comes from `srcB`, which holds the value of the register named in bits [20:16]. The word itself carries only the indices.

The trapping add and subtract forms raise an overflow flag and hold back the register write when the signed result does not fit. The wrapping forms always write. Any encoding the block does not know raises an illegal-instruction flag and never writes.

Top module: `int_exec_stage`

## Requirements
- R1: Register form (opcode 0) with function 0x20, 0x21, 0x22 or 0x23 yields srcA+srcB, srcA+srcB, srcA-srcB and srcA-srcB modulo 2^32. The destination is bits [15:11]. Functions 0x21 and 0x23 never raise `ovfTrap`.
- R2: For function 0x20 or 0x22, a signed result outside the 32-bit two's-complement range raises `ovfTrap` and forces `writeEn` low. Without such overflow, `ovfTrap` is low.
- R3: Register-form functions 0x24, 0x25, 0x26 and 0x27 yield srcA AND srcB, OR, XOR and NOR.
- R4: Functions 0, 2 and 3 shift srcB left logically, right logically and right arithmetically by bits [10:6]. For example, 0xabcd1234 shifted arithmetically right by 4 gives 0xfabcd123.
- R5: Functions 4, 6 and 7 do the same three shifts of srcB, but take the amount from srcA[4:0].
- R6: Opcodes 0x08 and 0x09 add the sign-extended 16-bit constant to srcA and write to bits [20:16]. Opcode 0x08 traps on signed overflow like R2. Opcode 0x09 never traps.
- R7: Opcodes 0x0c, 0x0d and 0x0e combine srcA with the zero-extended constant using AND, OR and XOR.
- R8: Opcode 0x0f yields the constant in bits [31:16] with the low 16 bits cleared.
- R9: A destination index of 0 never asserts `writeEn`. Any other legal, non-trapping instruction asserts it.
- R10: Any other opcode, or any other function value under opcode 0, sets `illegalOp`, with `writeEn` and `ovfTrap` low. Every decoded encoding leaves `illegalOp` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instrWord | input | 32 | Instruction word being executed |
| srcA | input | 32 | Value of the register named in bits [25:21] |
| srcB | input | 32 | Value of the register named in bits [20:16] |
| result | output | 32 | Computed result |
| destIdx | output | 5 | Destination register index |
| writeEn | output | 1 | Result may be written to destIdx |
| ovfTrap | output | 1 | Signed-overflow exception from a trapping form |
| illegalOp | output | 1 | Encoding not decoded |

## Verification
The embedded assertions check, for every input the stage sees, the relations between the write, trap and illegal flags. They check that add and subtract results invert back to their first operand, that the upper-immediate result has a clear low half, and that an arithmetic right shift keeps the sign bit. Only the bench's sweeps over every major opcode and every function code can show the exact values: the decode, the extension chosen for each constant, the shift amount source and fill, and the precise boundary at which signed overflow begins.

// File: rtl/int_exec_pkg.sv
package int_exec_pkg;

  localparam int INSTR_W = 32;
  localparam int OPC_W   = 6;
  localparam int FN_W    = 6;
  localparam int IMM_W   = 16;
  localparam int SA_W    = 5;

  localparam logic [OPC_W-1:0] OPC_REG   = 6'h00;
  localparam logic [OPC_W-1:0] OPC_ADDI  = 6'h08;
  localparam logic [OPC_W-1:0] OPC_ADDIU = 6'h09;
  localparam logic [OPC_W-1:0] OPC_ANDI  = 6'h0c;
  localparam logic [OPC_W-1:0] OPC_ORI   = 6'h0d;
  localparam logic [OPC_W-1:0] OPC_XORI  = 6'h0e;
  localparam logic [OPC_W-1:0] OPC_LUI   = 6'h0f;

  localparam logic [FN_W-1:0] FN_SLL  = 6'h00;
  localparam logic [FN_W-1:0] FN_SRL  = 6'h02;
  localparam logic [FN_W-1:0] FN_SRA  = 6'h03;
  localparam logic [FN_W-1:0] FN_SLLV = 6'h04;
  localparam logic [FN_W-1:0] FN_SRLV = 6'h06;
  localparam logic [FN_W-1:0] FN_SRAV = 6'h07;
  localparam logic [FN_W-1:0] FN_ADD  = 6'h20;
  localparam logic [FN_W-1:0] FN_ADDU = 6'h21;
  localparam logic [FN_W-1:0] FN_SUB  = 6'h22;
  localparam logic [FN_W-1:0] FN_SUBU = 6'h23;
  localparam logic [FN_W-1:0] FN_AND  = 6'h24;
  localparam logic [FN_W-1:0] FN_OR   = 6'h25;
  localparam logic [FN_W-1:0] FN_XOR  = 6'h26;
  localparam logic [FN_W-1:0] FN_NOR  = 6'h27;

  typedef enum logic [3:0] {
    OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_NOR,
    OP_SLL, OP_SRL, OP_SRA, OP_LUI
  } aluOp_e;

  typedef struct packed {
    aluOp_e aluOp;
    logic   useImm;
    logic   immSigned;
    logic   shiftVar;
    logic   trapOnOvf;
    logic   destIsRt;
    logic   legal;
  } ctrlStrobes_t;

endpackage

// File: rtl/int_exec_ctrl.sv
module int_exec_ctrl
  import int_exec_pkg::*;
#(
  parameter int REG_IDX_W = 5
) (
  input  logic [OPC_W-1:0]     opcode,
  input  logic [FN_W-1:0]      funct,
  input  logic [REG_IDX_W-1:0] rtIdx,
  input  logic [REG_IDX_W-1:0] rdIdx,
  input  logic                 ovfRaw,
  output ctrlStrobes_t         strobes,
  output logic [REG_IDX_W-1:0] destIdx,
  output logic                 writeEn,
  output logic                 ovfTrap,
  output logic                 illegalOp
);

  ctrlStrobes_t s;

  always_comb begin
    s       = '0;
    s.legal = 1'b1;
    if (opcode == OPC_REG) begin
      unique case (funct)
        FN_ADD:  begin s.aluOp = OP_ADD; s.trapOnOvf = 1'b1; end
        FN_ADDU: s.aluOp = OP_ADD;
        FN_SUB:  begin s.aluOp = OP_SUB; s.trapOnOvf = 1'b1; end
        FN_SUBU: s.aluOp = OP_SUB;
        FN_AND:  s.aluOp = OP_AND;
        FN_OR:   s.aluOp = OP_OR;
        FN_XOR:  s.aluOp = OP_XOR;
        FN_NOR:  s.aluOp = OP_NOR;
        FN_SLL:  s.aluOp = OP_SLL;
        FN_SRL:  s.aluOp = OP_SRL;
        FN_SRA:  s.aluOp = OP_SRA;
        FN_SLLV: begin s.aluOp = OP_SLL; s.shiftVar = 1'b1; end
        FN_SRLV: begin s.aluOp = OP_SRL; s.shiftVar = 1'b1; end
        FN_SRAV: begin s.aluOp = OP_SRA; s.shiftVar = 1'b1; end
        default: s.legal = 1'b0;
      endcase
    end else begin
      s.useImm   = 1'b1;
      s.destIsRt = 1'b1;
      unique case (opcode)
        OPC_ADDI:  begin s.aluOp = OP_ADD; s.immSigned = 1'b1; s.trapOnOvf = 1'b1; end
        OPC_ADDIU: begin s.aluOp = OP_ADD; s.immSigned = 1'b1; end
        OPC_ANDI:  s.aluOp = OP_AND;
        OPC_ORI:   s.aluOp = OP_OR;
        OPC_XORI:  s.aluOp = OP_XOR;
        OPC_LUI:   s.aluOp = OP_LUI;
        default:   s.legal = 1'b0;
      endcase
    end
  end

  assign strobes   = s;
  assign destIdx   = s.destIsRt ? rtIdx : rdIdx;
  assign illegalOp = !s.legal;
  assign ovfTrap   = s.legal && s.trapOnOvf && ovfRaw;
  assign writeEn   = s.legal && !ovfTrap && (destIdx != '0);

endmodule

// File: rtl/int_exec_dpath.sv
module int_exec_dpath
  import int_exec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  ctrlStrobes_t     strobes,
  input  logic [XLEN-1:0]  srcA,
  input  logic [XLEN-1:0]  srcB,
  input  logic [IMM_W-1:0] imm,
  input  logic [SA_W-1:0]  saField,
  output logic [XLEN-1:0]  result,
  output logic             ovfRaw
);

  localparam int SHAMT_W = $clog2(XLEN);
  localparam int EXT_W   = XLEN - IMM_W;

  logic [XLEN-1:0]    immExt;
  logic [XLEN-1:0]    opB;
  logic [XLEN-1:0]    addB;
  logic [XLEN-1:0]    sum;
  logic [SHAMT_W-1:0] shAmt;
  logic               isSub;

  assign immExt = strobes.immSigned ? {{EXT_W{imm[IMM_W-1]}}, imm}
                                    : {{EXT_W{1'b0}}, imm};
  assign opB    = strobes.useImm ? immExt : srcB;
  assign isSub  = (strobes.aluOp == OP_SUB);
  assign addB   = isSub ? ~opB : opB;
  assign sum    = srcA + addB + XLEN'(isSub);
  assign ovfRaw = (srcA[XLEN-1] == addB[XLEN-1]) && (sum[XLEN-1] != srcA[XLEN-1]);
  assign shAmt  = strobes.shiftVar ? srcA[SHAMT_W-1:0] : SHAMT_W'(saField);

  always_comb begin
    unique case (strobes.aluOp)
      OP_ADD, OP_SUB: result = sum;
      OP_AND:  result = srcA & opB;
      OP_OR:   result = srcA | opB;
      OP_XOR:  result = srcA ^ opB;
      OP_NOR:  result = ~(srcA | opB);
      OP_SLL:  result = srcB << shAmt;
      OP_SRL:  result = srcB >> shAmt;
      OP_SRA:  result = $signed(srcB) >>> shAmt;
      OP_LUI:  result = {{EXT_W{1'b0}}, imm} << IMM_W;
      default: result = '0;
    endcase
  end

  always_comb begin
    // R1
    add_inverse_chk: assert (!(strobes.legal && strobes.aluOp == OP_ADD) || (result - opB == srcA));
    // R1
    sub_inverse_chk: assert (!(strobes.legal && strobes.aluOp == OP_SUB) || (result + opB == srcA));
    // R8
    lui_low_clear_chk: assert (!(strobes.legal && strobes.aluOp == OP_LUI) || (result[IMM_W-1:0] == '0));
    // R4
    sra_sign_keep_chk: assert (!(strobes.legal && strobes.aluOp == OP_SRA) || (result[XLEN-1] == srcB[XLEN-1]));
  end

endmodule

// File: rtl/int_exec_stage.sv
module int_exec_stage
  import int_exec_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int REG_IDX_W = 5
) (
  input  logic [INSTR_W-1:0]   instrWord,
  input  logic [XLEN-1:0]      srcA,
  input  logic [XLEN-1:0]      srcB,
  output logic [XLEN-1:0]      result,
  output logic [REG_IDX_W-1:0] destIdx,
  output logic                 writeEn,
  output logic                 ovfTrap,
  output logic                 illegalOp
);

  ctrlStrobes_t strobes;
  logic         ovfRaw;
  logic         unusedRsField;

  assign unusedRsField = ^instrWord[25:21];

  int_exec_ctrl #(.REG_IDX_W(REG_IDX_W)) u_ctrl (
    .opcode   (instrWord[31:26]),
    .funct    (instrWord[5:0]),
    .rtIdx    (instrWord[20:16]),
    .rdIdx    (instrWord[15:11]),
    .ovfRaw   (ovfRaw),
    .strobes  (strobes),
    .destIdx  (destIdx),
    .writeEn  (writeEn),
    .ovfTrap  (ovfTrap),
    .illegalOp(illegalOp)
  );

  int_exec_dpath #(.XLEN(XLEN)) u_dpath (
    .strobes (strobes),
    .srcA    (srcA),
    .srcB    (srcB),
    .imm     (instrWord[15:0]),
    .saField (instrWord[10:6]),
    .result  (result),
    .ovfRaw  (ovfRaw)
  );

  always_comb begin
    // R10
    no_write_illegal_chk: assert (!(illegalOp && writeEn));
    // R10
    no_trap_illegal_chk: assert (!(illegalOp && ovfTrap));
    // R2
    no_write_on_trap_chk: assert (!(ovfTrap && writeEn));
    // R9
    zero_dest_chk: assert (!(writeEn && destIdx == '0));
  end

endmodule

// File: tb/int_exec_stage_bench.sv
`timescale 1ns/1ps
module int_exec_stage_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instrWord, srcA, srcB;
  logic [31:0] result;
  logic [4:0]  destIdx;
  logic        writeEn, ovfTrap, illegalOp;
  int          total = 0;
  int          bad   = 0;

  always #10 clk = ~clk;

  int_exec_stage u_int_exec_stage (
    .instrWord(instrWord), .srcA(srcA), .srcB(srcB), .result(result),
    .destIdx(destIdx), .writeEn(writeEn), .ovfTrap(ovfTrap), .illegalOp(illegalOp)
  );

  logic [31:0] opA [8] = '{32'h0000_0000, 32'h7fff_ffff, 32'h8000_0000, 32'hffff_ffff,
                           32'habcd_1234, 32'h0000_0001, 32'h1234_5678, 32'h8000_0001};
  logic [31:0] opBv[8] = '{32'h0000_0000, 32'h0000_0001, 32'h8000_0000, 32'hffff_0000,
                           32'h7fff_ffff, 32'hffff_ffff, 32'habcd_1234, 32'h0000_0013};

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic sovf(input logic [31:0] a, input logic [31:0] b, input logic sub);
    longint s;
    s = sub ? longint'($signed(a)) - longint'($signed(b)) : longint'($signed(a)) + longint'($signed(b));
    return (s > 64'sd2147483647) || (s < -64'sd2147483648);
  endfunction

  task automatic runOne(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b);
    logic [5:0]  op = ins[31:26];
    logic [5:0]  fn = ins[5:0];
    logic [4:0]  sa = ins[10:6];
    logic [15:0] im = ins[15:0];
    logic [31:0] sx = {{16{im[15]}}, im};
    logic [31:0] zx = {16'h0, im};
    logic [31:0] r  = '0;
    logic [4:0]  d;
    logic        ov = 1'b0;
    logic        il = 1'b0;
    logic        we;
    string       tag;
    d = (op == 6'h00) ? ins[15:11] : ins[20:16];
    if (op == 6'h00) begin
      case (fn)
        6'h20: begin r = a + b; ov = sovf(a, b, 1'b0); tag = "R2"; end
        6'h21: begin r = a + b; tag = "R1"; end
        6'h22: begin r = a - b; ov = sovf(a, b, 1'b1); tag = "R2"; end
        6'h23: begin r = a - b; tag = "R1"; end
        6'h24: begin r = a & b; tag = "R3"; end
        6'h25: begin r = a | b; tag = "R3"; end
        6'h26: begin r = a ^ b; tag = "R3"; end
        6'h27: begin r = ~(a | b); tag = "R3"; end
        6'h00: begin r = b << sa; tag = "R4"; end
        6'h02: begin r = b >> sa; tag = "R4"; end
        6'h03: begin r = $signed(b) >>> sa; tag = "R4"; end
        6'h04: begin r = b << a[4:0]; tag = "R5"; end
        6'h06: begin r = b >> a[4:0]; tag = "R5"; end
        6'h07: begin r = $signed(b) >>> a[4:0]; tag = "R5"; end
        default: il = 1'b1;
      endcase
    end else begin
      case (op)
        6'h08: begin r = a + sx; ov = sovf(a, sx, 1'b0); tag = "R6"; end
        6'h09: begin r = a + sx; tag = "R6"; end
        6'h0c: begin r = a & zx; tag = "R7"; end
        6'h0d: begin r = a | zx; tag = "R7"; end
        6'h0e: begin r = a ^ zx; tag = "R7"; end
        6'h0f: begin r = {im, 16'h0}; tag = "R8"; end
        default: il = 1'b1;
      endcase
    end
    we = !il && !ov && (d != 5'd0);
    if (il) tag = "R10";
    else if (d == 5'd0) tag = "R9";
    @(posedge clk); #2;
    instrWord = ins; srcA = a; srcB = b;
    #6;
    check(tag, "illegalOp", {31'b0, illegalOp}, {31'b0, il});
    check(tag, "writeEn",   {31'b0, writeEn},   {31'b0, we});
    check(tag, "ovfTrap",   {31'b0, ovfTrap},   {31'b0, ov});
    if (!il) begin
      check(tag, "result",  result, r);
      check(tag, "destIdx", {27'b0, destIdx}, {27'b0, d});
    end
  endtask

  initial begin
    #(20 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    instrWord = '0; srcA = '0; srcB = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    #8;
    // R9 idle word: shift into register 0, nothing written
    check("R9", "idle writeEn", {31'b0, writeEn}, 32'd0);
    check("R10", "idle illegalOp", {31'b0, illegalOp}, 32'd0);
    // R4 directed arithmetic right shift example
    runOne({6'h00, 5'd0, 5'd18, 5'd17, 5'd4, 6'h03}, 32'h0, 32'habcd1234);
    check("R4", "sra example", result, 32'hfabcd123);
    // R2 / R6 overflow boundaries
    runOne({6'h00, 5'd1, 5'd2, 5'd3, 5'd0, 6'h20}, 32'h7fffffff, 32'h1);
    runOne({6'h00, 5'd1, 5'd2, 5'd3, 5'd0, 6'h22}, 32'h0, 32'h80000000);
    runOne({6'h00, 5'd1, 5'd2, 5'd3, 5'd0, 6'h22}, 32'hffffffff, 32'h80000000);
    runOne({6'h08, 5'd1, 5'd2, 16'h0001}, 32'h7fffffff, 32'h0);
    runOne({6'h08, 5'd1, 5'd2, 16'hffff}, 32'h80000000, 32'h0);
    runOne({6'h09, 5'd1, 5'd2, 16'hffff}, 32'h80000000, 32'h0);
    // R8 upper immediate
    runOne({6'h0f, 5'd0, 5'd17, 16'hac51}, 32'h0, 32'h0);
    // R1 R2 R3 R4 R5 R9 R10: every function code, varied operands, shift amounts and dest
    for (int f = 0; f < 64; f++) begin
      for (int k = 0; k < 8; k++) begin
        runOne({6'h00, 5'd3, 5'd4, 5'(k * 5 % 8), 5'(k * 7 + f), 6'(f)}, opA[k], opBv[(k + f) % 8]);
      end
    end
    // R6 R7 R8 R9 R10: every major opcode with several constants and dest values
    for (int o = 1; o < 64; o++) begin
      for (int k = 0; k < 8; k++) begin
        runOne({6'(o), 5'd2, 5'(k * 3 % 8), opBv[(k + o) % 8][15:0] ^ 16'(k * 16'h1111)}, opA[k], opBv[k]);
      end
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule